// File: doc/BRIEF.md
# Transceiver Loop Delay Measurement Unit

This block finds out how long a bit takes to travel from the controller's transmit output, through the local transceiver, and back to its receive input. The measurement runs inside each CAN FD frame that the node transmits. A protocol engine, which sits outside this block, raises a one-cycle strobe in the cycle where the transmitter drives the falling edge between the FDF and res bits. From that point the unit counts controller clock periods. One clock period is one minimum time quantum. Counting stops when the dominant level comes back on the synchronized receive line. The count is then reported as a 7-bit delay, together with a one-cycle valid pulse. Bit timing logic uses this delay to place its secondary sample point.

A short dominant glitch in the received FDF bit could end the count too early. To prevent this, a programmable filter window sets the lowest count at which the unit accepts a dominant sample. Dominant samples that arrive before that count are ignored. The count saturates at its top value, so it never wraps. An init control clears the reported value and cancels a measurement that is in progress. The enable input gates the whole function.

Top module: `tdm_meas_top`

## Requirements
- R1: A strobe on `edge_stb_i` starts a measurement only when `comp_en_i` is 1 and `init_i` is 0 at that clock edge. Otherwise the strobe produces no valid pulse and leaves `dly_o` unchanged.
- R2: The strobe is sampled at edge E0. If the first qualifying low sample of `rx_i` (0 = dominant) is taken at edge Ek, then `dly_o` equals k after Ek. The smallest value that can be reported is 1.
- R3: A low sample of `rx_i` at Ek with k below `filt_min_i` is ignored. The measurement stops at the first edge where k is at least `filt_min_i` and `rx_i` is 0. A value of 0 in `filt_min_i` disables the filter.
- R4: If `rx_i` is already 0 when counting starts, the stop condition applies from the first count. With `filt_min_i` at 1 or below, the result is 1.
- R5: If no qualifying low sample arrives by count 127, the measurement ends and reports 127. The count never wraps.
- R6: `dly_vld_o` is high for exactly one cycle, in the same cycle that a new `dly_o` value first appears. `dly_o` holds its value between updates.
- R7: While `init_i` is 1, `dly_o` is cleared to 0. A measurement in progress is abandoned without a valid pulse.
- R8: A strobe that arrives while a measurement is in progress is ignored. The running count is not restarted.
- R9: If `comp_en_i` goes to 0 during a measurement, the measurement is abandoned. No valid pulse follows, and `dly_o` keeps its previous value.
- R10: After synchronous reset, `dly_o` is 0 and `dly_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one period is one minimum time quantum |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Init control; clears the result and cancels any measurement |
| comp_en_i | input | 1 | Delay compensation enable |
| edge_stb_i | input | 1 | One-cycle strobe at the transmitted FDF-to-res falling edge |
| rx_i | input | 1 | Synchronized receive line, 0 = dominant |
| filt_min_i | input | 7 | Filter window: smallest count at which a dominant sample is accepted |
| dly_o | output | 7 | Measured loop delay in clock periods |
| dly_vld_o | output | 1 | One-cycle pulse marking a new `dly_o` value |

## Verification
The assertions assume that `rx_i` is already synchronized to `clk`. They also assume that `filt_min_i` does not change during a measurement, so the filter bound seen at the stop edge is the one the result must meet. They further assume that strobes come from an engine that sends at most one per frame, although the RTL tolerates extra strobes. The stimulus meets these assumptions in the following way. It drives every input on the falling clock edge. It loads the filter window before each strobe and holds it until the run ends. It uses extra strobes only on purpose, inside a running count, to exercise R8.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Width of the reported delay; the count saturates at 2**DLY_W - 1.
    localparam int DLY_W = 7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } meas_state_e;

    // One-hot command issued by the control unit each cycle.
    typedef struct packed {
        logic start;   // clear counter, enter counting
        logic step;    // advance counter by one quantum
        logic finish;  // capture candidate count as result
        logic abort;   // drop measurement without result
    } meas_cmd_t;

    localparam meas_cmd_t CMD_NONE = '{start: 1'b0, step: 1'b0, finish: 1'b0, abort: 1'b0};

    // Stop decision: a dominant sample past the filter bound, or saturation.
    function automatic logic stop_hit(input logic rx_low,
                                      input logic past_filter,
                                      input logic saturated);
        return (rx_low && past_filter) || saturated;
    endfunction

    // A strobe may start a run only when enabled and not in init.
    function automatic logic start_ok(input logic stb,
                                      input logic en,
                                      input logic init);
        return stb && en && !init;
    endfunction

endpackage

// File: rtl/tdm_counter.sv
module tdm_counter
    import tdm_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cand_o,
    output logic         sat_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    // Candidate is the count that the current edge would represent (R2, R5).
    always_comb begin
        if (cnt_q == CNT_MAX) begin
            cand_o = CNT_MAX;
        end else begin
            cand_o = cnt_q + CNT_ONE;
        end
        sat_o = (cand_o == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cand_o;
        end
    end

endmodule

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
    import tdm_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         en_i,
    input  logic         stb_i,
    input  logic         rx_i,
    input  logic [W-1:0] filt_min_i,
    input  logic [W-1:0] cand_i,
    input  logic         sat_i,
    output meas_cmd_t    cmd_o
);
    meas_state_e state_q, state_d;
    logic        rx_low;
    logic        past_filt;

    assign rx_low    = !rx_i;
    assign past_filt = (cand_i >= filt_min_i);   // R3

    always_comb begin
        cmd_o   = CMD_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok(stb_i, en_i, init_i)) begin   // R1
                    cmd_o.start = 1'b1;
                    state_d     = ST_RUN;
                end
            end
            ST_RUN: begin
                // Strobes are not looked at here (R8).
                if (init_i || !en_i) begin                  // R7, R9
                    cmd_o.abort = 1'b1;
                    state_d     = ST_IDLE;
                end else if (stop_hit(rx_low, past_filt, sat_i)) begin  // R2..R5
                    cmd_o.finish = 1'b1;
                    state_d      = ST_IDLE;
                end else begin
                    cmd_o.step = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tdm_result.sv
module tdm_result
    import tdm_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dly_o,
    output logic         vld_o
);
    always_ff @(posedge clk) begin
        if (rst || init_i) begin            // R10, R7
            dly_o <= '0;
            vld_o <= 1'b0;
        end else if (load_i) begin          // R6
            dly_o <= val_i;
            vld_o <= 1'b1;
        end else begin
            vld_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tdm_meas_top.sv
module tdm_meas_top
    import tdm_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         comp_en_i,
    input  logic         edge_stb_i,
    input  logic         rx_i,
    input  logic [W-1:0] filt_min_i,
    output logic [W-1:0] dly_o,
    output logic         dly_vld_o
);
    meas_cmd_t    cmd;
    logic [W-1:0] cand;
    logic         sat;

    tdm_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init_i),
        .en_i       (comp_en_i),
        .stb_i      (edge_stb_i),
        .rx_i       (rx_i),
        .filt_min_i (filt_min_i),
        .cand_i     (cand),
        .sat_i      (sat),
        .cmd_o      (cmd)
    );

    tdm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cmd.start),
        .inc_i  (cmd.step),
        .cand_o (cand),
        .sat_o  (sat)
    );

    tdm_result #(.W(W)) u_res (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_i),
        .load_i (cmd.finish),
        .val_i  (cand),
        .dly_o  (dly_o),
        .vld_o  (dly_vld_o)
    );

endmodule

// File: rtl/tdm_meas_chk.sv
module tdm_meas_chk #(
    parameter int W = tdm_pkg::DLY_W
) (
    input logic         clk,
    input logic         rst,
    input logic         init_i,
    input logic         comp_en_i,
    input logic         rx_i,
    input logic [W-1:0] filt_min_i,
    input logic [W-1:0] dly_o,
    input logic         dly_vld_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dly_vld_o |=> !dly_vld_o);                                   // R6
    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (dly_o == '0) && !dly_vld_o);                     // R7
    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        dly_vld_o |-> $past(comp_en_i && !init_i));                  // R9
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (dly_vld_o && dly_o != TOP) |-> $past(!rx_i));               // R2
    AST_FILTER_BOUND: assert property (@(posedge clk) disable iff (rst)
        dly_vld_o |-> (dly_o >= $past(filt_min_i)));                 // R3
    AST_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dly_vld_o |-> (dly_o != '0));                                // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!dly_vld_o && !$past(init_i)) |-> $stable(dly_o));          // R6

endmodule

bind tdm_meas_top tdm_meas_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .comp_en_i  (comp_en_i),
    .rx_i       (rx_i),
    .filt_min_i (filt_min_i),
    .dly_o      (dly_o),
    .dly_vld_o  (dly_vld_o)
);

// File: tb/sim_tdm_meas_top.sv
module sim_tdm_meas_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       init_i;
    logic       comp_en_i;
    logic       edge_stb_i;
    logic       rx_i;
    logic [6:0] filt_min_i;
    logic [6:0] dly_o;
    logic       dly_vld_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    int model_dly = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tdm_meas_top u0 (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init_i),
        .comp_en_i  (comp_en_i),
        .edge_stb_i (edge_stb_i),
        .rx_i       (rx_i),
        .filt_min_i (filt_min_i),
        .dly_o      (dly_o),
        .dly_vld_o  (dly_vld_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected results as valid pulses appear (R2, R6).
    always @(negedge clk) begin
        if (!rst && dly_vld_o) begin
            if (exp_q.size() == 0) begin
                check({cur_req, " unexpected valid"}, 1, 0);
            end else begin
                check({cur_req, " delay"}, int'(dly_o), exp_q.pop_front());
            end
        end
    end

    // Driver: k counts edges after the strobe edge E0; 0 in an argument means unused.
    task automatic measure(input string req, input int low_at, input int glitch_at,
                           input int filt, input int extra_stb, input int en_drop_at,
                           input int init_at);
        int stop = 0;
        cur_req = req;
        for (int k = 1; k <= 127; k++) begin
            bit low;
            if (k == init_at || (en_drop_at > 0 && k >= en_drop_at)) break;
            low = (k >= low_at) || (k == glitch_at);
            if ((low && k >= filt) || k == 127) begin
                stop = k;
                break;
            end
        end
        if (stop > 0) begin
            exp_q.push_back(stop);
            model_dly = stop;
        end
        if (init_at > 0) model_dly = 0;
        filt_min_i = 7'(filt);
        for (int k = 0; k <= 130; k++) begin
            @(negedge clk);
            edge_stb_i = (k == 0) || (k == extra_stb && k > 0);
            rx_i       = !((k >= low_at) || (k == glitch_at && k > 0));
            comp_en_i  = !(en_drop_at > 0 && k >= en_drop_at);
            init_i     = (k == init_at && k > 0);
        end
        @(negedge clk);
        edge_stb_i = 1'b0; rx_i = 1'b1; comp_en_i = 1'b1; init_i = 1'b0;
        repeat (3) @(negedge clk);
        check({req, " pending results"}, exp_q.size(), 0);
        check({req, " held value"}, int'(dly_o), model_dly);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; init_i = 1'b0; comp_en_i = 1'b1; edge_stb_i = 1'b0;
        rx_i = 1'b1; filt_min_i = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset delay", int'(dly_o), 0);
        check("R10 reset valid", int'(dly_vld_o), 0);

        measure("R2 plain", 9, 0, 0, 0, 0, 0);
        measure("R2 long", 40, 0, 5, 0, 0, 0);
        measure("R3 glitch ignored", 20, 4, 10, 0, 0, 0);
        measure("R3 low at bound", 3, 0, 12, 0, 0, 0);
        measure("R3 glitch unfiltered", 20, 4, 0, 0, 0, 0);
        measure("R4 already low", 0, 0, 0, 0, 0, 0);
        measure("R4 already low filt", 0, 0, 6, 0, 0, 0);
        measure("R5 no edge", 500, 0, 0, 0, 0, 0);
        measure("R5 filter top", 5, 0, 127, 0, 0, 0);
        measure("R5 edge at top", 127, 0, 0, 0, 0, 0);
        measure("R8 second strobe", 10, 0, 0, 3, 0, 0);
        measure("R9 enable drop", 10, 0, 0, 0, 4, 0);
        measure("R7 init abort", 10, 0, 0, 0, 0, 5);

        // R1: strobe with enable low does nothing.
        measure("R2 before R1", 15, 0, 0, 0, 0, 0);
        cur_req = "R1";
        @(negedge clk);
        comp_en_i = 1'b0; edge_stb_i = 1'b1; rx_i = 1'b1;
        @(negedge clk);
        edge_stb_i = 1'b0;
        repeat (4) @(negedge clk);
        rx_i = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 disabled strobe", int'(dly_o), 15);
        // R1: strobe during init does nothing.
        comp_en_i = 1'b1; init_i = 1'b1; edge_stb_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0; edge_stb_i = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 strobe in init", int'(dly_o), 0);
        check("R7 cleared by init", int'(dly_vld_o), 0);
        rx_i = 1'b1;
        model_dly = 0;
        measure("R6 after init", 7, 0, 0, 0, 0, 0);

        finish_run();
    end

endmodule